// File: doc/BRIEF.md
# Binary Tree Up/Down Route Unit

This block decides the next hop for a packet at one switch of a binary tree or fat-tree. The tree holds N = 2^ADDR_W leaves, numbered 0 to N-1, and has height ADDR_W. Each leaf address, read from its most significant bit down, gives the path from the root to that leaf. The unit receives three inputs for each packet: the source leaf, the destination leaf, and the level of the switch asking for the route. Leaves are at level 0 and the root switches are at level ADDR_W.

The unit XORs the two leaf addresses and finds the highest set bit of the result, at position i. From that bit it derives the turnaround level i+1. At that level the two leaves share a common ancestor. A switch below the turnaround level forwards the packet upward. A switch at or above the turnaround level forwards it downward, to the child given by destination bit L-1, where L is the switch's own level.

The unit also reports:
- the whole downward steering path,
- a local-delivery flag, set when source and destination are the same leaf,
- the total hop count, for a statistics counter.

All results appear one clock after the request, through one register stage.

Top module: `tree_route_unit`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high. It is low one clock after a cycle in which `in_valid` was low.
- R2: While `rst_n` is low, and after reset until the first request, every output is zero.
- R3: `turn_level` equals one plus the bit position of the most significant 1 in `src ^ dst`. When `src` equals `dst`, `turn_level` is 0.
- R4: `local_deliver` is 1 exactly when `src` equals `dst`.
- R5: `hop_count` equals twice `turn_level`. It is 0 for local delivery.
- R6: `go_up` is 1 exactly when the request's `level` is less than `turn_level`.
- R7: When `go_up` is 0 and `level` is between 1 and ADDR_W, `child` equals `dst` bit `level-1`, where 0 is the left child and 1 is the right child. In every other case `child` is 0.
- R8: `down_path` equals `dst` with every bit at position `turn_level` and above cleared. For local delivery it is all zero.
- R9: In a cycle with `in_valid` low, the route outputs (`local_deliver`, `turn_level`, `hop_count`, `go_up`, `child`, `down_path`) keep the values of the last request. This holds whatever `src`, `dst` and `level` carry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | ADDR_W | Source leaf address |
| dst | input | ADDR_W | Destination leaf address |
| level | input | LVL_W | Level of the requesting switch (0 = leaf) |
| out_valid | output | 1 | Result valid |
| local_deliver | output | 1 | Source and destination are the same leaf |
| turn_level | output | LVL_W | Level of the common ancestor, 0 if local |
| hop_count | output | LVL_W+1 | Total hops up and down |
| go_up | output | 1 | Forward toward the root at this level |
| child | output | 1 | Child branch when forwarding down |
| down_path | output | ADDR_W | Destination bits that steer the descent |

## Verification
Two situations are the hardest to reach from the ports.

The first is a route whose turnaround is at the root. Here the two addresses differ in their most significant bit, and the request must come from a switch at level ADDR_W, where `go_up` changes from 1 to 0. Uniformly random addresses give few such pairs at exactly the boundary level, so directed pairs that differ only in the top bit or only in the bottom bit are applied at every level from 0 to ADDR_W.

The second is the hold behaviour. It is only observable when the idle-cycle inputs differ from those of the previous request. The bench therefore drives fresh random values on idle cycles and compares the outputs against the earlier request's expected values.

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LVL_W-1:0]  level,
  output logic              out_valid,
  output logic              local_deliver,
  output logic [LVL_W-1:0]  turn_level,
  output logic [LVL_W:0]    hop_count,
  output logic              go_up,
  output logic              child,
  output logic [ADDR_W-1:0] down_path
);

  logic [ADDR_W-1:0] rel;
  logic [LVL_W-1:0]  turn_c;
  logic [ADDR_W-1:0] path_c;
  logic              up_c;
  logic              child_c;

  assign rel  = src ^ dst;
  assign up_c = level < turn_c;

  always_comb begin
    turn_c = '0;
    for (int j = 0; j < ADDR_W; j++)
      if (rel[j]) turn_c = LVL_W'(j + 1);
  end

  always_comb begin
    for (int j = 0; j < ADDR_W; j++)
      path_c[j] = dst[j] & (LVL_W'(j) < turn_c);
  end

  always_comb begin
    child_c = 1'b0;
    for (int j = 0; j < ADDR_W; j++)
      if (level == LVL_W'(j + 1) && !up_c) child_c = dst[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      local_deliver <= 1'b0;
      turn_level    <= '0;
      hop_count     <= '0;
      go_up         <= 1'b0;
      child         <= 1'b0;
      down_path     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        local_deliver <= (rel == '0);
        turn_level    <= turn_c;
        hop_count     <= {turn_c, 1'b0};
        go_up         <= up_c;
        child         <= child_c;
        down_path     <= path_c;
      end
    end
  end

endmodule

// File: rtl/tree_route_chk.sv
module tree_route_chk #(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] src,
  input logic [ADDR_W-1:0] dst,
  input logic [LVL_W-1:0]  level,
  input logic              out_valid,
  input logic              local_deliver,
  input logic [LVL_W-1:0]  turn_level,
  input logic [LVL_W:0]    hop_count,
  input logic              go_up,
  input logic              child,
  input logic [ADDR_W-1:0] down_path
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid)); // R1

  AST_TURN_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && in_valid) && !local_deliver) |->
      (turn_level != '0 &&
       (($past(src ^ dst) >> (turn_level - LVL_W'(1))) == ADDR_W'(1)))); // R3

  AST_LOCAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid) |-> local_deliver == ($past(src) == $past(dst))); // R4

  AST_HOPS_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hop_count == {turn_level, 1'b0}); // R5

  AST_UP_BELOW_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid) |-> go_up == ($past(level) < turn_level)); // R6

  AST_UP_NO_CHILD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && go_up) |-> !child); // R7

  AST_PATH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (down_path >> turn_level) == '0); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |->
      ($stable(turn_level) && $stable(down_path) && $stable(go_up) && $stable(child))); // R9

endmodule

bind tree_route_unit tree_route_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_tree_route_unit.sv
module sim_tree_route_unit;
  localparam int ADDR_W = 4;
  localparam int LVL_W  = $clog2(ADDR_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [ADDR_W-1:0] src = '0, dst = '0;
  logic [LVL_W-1:0]  level = '0;
  logic              out_valid, local_deliver, go_up, child;
  logic [LVL_W-1:0]  turn_level;
  logic [LVL_W:0]    hop_count;
  logic [ADDR_W-1:0] down_path;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic              e_loc, e_up, e_child;
  logic [LVL_W-1:0]  e_turn;
  logic [ADDR_W-1:0] e_path;

  always #5 clk = ~clk;

  tree_route_unit #(.ADDR_W(ADDR_W)) u0 (.*);

  function automatic logic [LVL_W-1:0] ref_turn(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] r = a ^ b;
    for (int j = ADDR_W - 1; j >= 0; j--)
      if (r[j]) return LVL_W'(j + 1);
    return '0;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_expect(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] d, logic [LVL_W-1:0] l);
    e_turn  = ref_turn(s, d);
    e_loc   = (s == d);
    e_up    = l < e_turn;
    e_child = (!e_up && l >= 1 && l <= ADDR_W) ? d[l-1] : 1'b0;
    e_path  = '0;
    for (int j = 0; j < ADDR_W; j++)
      if (j < e_turn) e_path[j] = d[j];
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3 turn"}, turn_level, e_turn);
    chk({tag, " R4 local"}, local_deliver, e_loc);
    chk({tag, " R5 hops"}, hop_count, 2 * e_turn);
    chk({tag, " R6 up"}, go_up, e_up);
    chk({tag, " R7 child"}, child, e_child);
    chk({tag, " R8 path"}, down_path, e_path);
  endtask

  task automatic apply(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] d, logic [LVL_W-1:0] l);
    @(negedge clk);
    in_valid = 1'b1; src = s; dst = d; level = l;
    set_expect(s, d, l);
    @(posedge clk); #1;
    chk("R1 valid", out_valid, 1);
    check_all("req");
    @(negedge clk);
    in_valid = 1'b0;
    src = ADDR_W'($urandom); dst = ADDR_W'($urandom); level = LVL_W'($urandom_range(ADDR_W));
    @(posedge clk); #1;
    chk("R1 idle", out_valid, 0);
    check_all("R9 hold");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R2 valid", out_valid, 0);
    chk("R2 turn", turn_level, 0);
    chk("R2 path", down_path, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 after", hop_count, 0);
    for (int l = 0; l <= ADDR_W; l++) begin
      apply(ADDR_W'(5), ADDR_W'(5), LVL_W'(l));
      apply(ADDR_W'(0), ADDR_W'(1) << (ADDR_W - 1), LVL_W'(l));
      apply({ADDR_W{1'b1}}, ADDR_W'(0), LVL_W'(l));
      apply(ADDR_W'(6), ADDR_W'(7), LVL_W'(l));
      apply(ADDR_W'(2), ADDR_W'(9), LVL_W'(l));
    end
    for (int n = 0; n < 400; n++)
      apply(ADDR_W'($urandom), ADDR_W'($urandom), LVL_W'($urandom_range(ADDR_W)));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule